// File: doc/BRIEF.md
# Differential Symbol Encoder with Bit-Order Mapping

This block sits in a burst modulator's data path, between the serial bit source and the constellation mapper. It collects serial data bits, arriving one per bit strobe, into symbols of one bit (BPSK), two bits (QPSK) or four bits (16QAM). It can reverse the order of the bits within a symbol and can differentially encode the quadrant bits against the previous output symbol. The result is one 4-bit symbol word `{I1,Q1,I0,Q0}` for each symbol strobe.

The differential reference is the quadrant pair `{I1,Q1}` of the last symbol the block produced. Suppose the encoder is enabled during the preamble and stays enabled. Then the first user symbol is encoded against the last preamble symbol. Suppose instead that the enable is first raised on the first user symbol. Then that symbol is encoded against a zero reference.

Top module: `diffmap_top`

## Requirements
- R1: After reset, `sym_vld` is 0, `sym_out` is 4'b0000 and the differential reference is zero. The first differentially encoded symbol after reset is therefore encoded against 2'b00.
- R2: `sym_vld` is high for exactly the one cycle after each clock edge that samples `sym_stb` high, and `sym_out` presents the new symbol in that same cycle. `sym_out` holds its value until the next symbol. The symbol is built from the most recent bits sampled with `bit_stb`, including a bit sampled on the same edge as `sym_stb`.
- R3: With `mod_sel`=2'b00 (BPSK), the last bit b forms the symbol, and without differential encoding `sym_out`={b,b,b,b}. With differential encoding on, b=1 inverts both quadrant bits (a 180° phase change) and b=0 leaves them unchanged.
- R4: With `mod_sel`=2'b01 (QPSK), the two most recent bits form the symbol. With natural order, the older bit b0 drives I and the newer bit b1 drives Q, and the block always outputs I1=I0 and Q1=Q0.
- R5: With `mod_sel`=2'b10 or 2'b11 (16QAM), the four most recent bits b0 (oldest) to b3 form the symbol. With natural order, `sym_out`={I1,Q1,I0,Q0}={b0,b1,b2,b3}.
- R6: `map_sel[2]`=1 reverses the bit order within the symbol: 16QAM gives {b3,b2,b1,b0}, and QPSK gives I=b1, Q=b0. BPSK is unaffected. `map_sel[2]`=0 gives natural order, and `map_sel[1:0]` has no effect on the output.
- R7: With `diff_en` high on both this symbol and the previous one, the output quadrant bits {I1,Q1} are the input quadrant bits XOR the {I1,Q1} of the previous output symbol.
- R8: In 16QAM, I0 and Q0 pass through unchanged whether differential encoding is on or off.
- R9: A symbol that has `diff_en` high after a symbol with `diff_en` low (or as the first symbol after reset) is encoded against a zero reference.
- R10: With `diff_en` low, the symbol passes through without encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Samples `bit_in` into the bit window |
| bit_in | input | 1 | Serial data bit |
| sym_stb | input | 1 | Forms and encodes one symbol |
| mod_sel | input | 2 | 00 BPSK, 01 QPSK, 1x 16QAM; sampled with `sym_stb` |
| diff_en | input | 1 | Differential encoding enable; sampled with `sym_stb` |
| map_sel | input | 3 | Bit 2 reverses symbol bit order; bits 1:0 have no effect |
| sym_out | output | 4 | Symbol word {I1,Q1,I0,Q0} |
| sym_vld | output | 1 | One-cycle pulse marking a new symbol |

## Verification
Each symbol is due exactly one clock after the edge that samples `sym_stb`. The driver changes inputs on the falling edge, so the monitor looks for `sym_vld` on the next falling edge and compares `sym_out` there against the head of an expected queue. On every other falling edge the monitor checks that `sym_out` holds its last value. Any `sym_vld` that arrives with no expected entry waiting counts as a failure. Stretches that toggle `diff_en`, together with runs of random symbols, test the reference and zero-reference timing against a model that the bench keeps independently.

// File: rtl/diffmap_pkg.sv
package diffmap_pkg;
  localparam int SYM_BITS  = 4;
  localparam int QUAD_BITS = SYM_BITS / 2;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'b00,
    MOD_QPSK  = 2'b01,
    MOD_QAM16 = 2'b10,
    MOD_QAM16B = 2'b11
  } mod_e;

  function automatic logic is_qam16(input mod_e m);
    return m[1];
  endfunction

  // win[0] is the newest bit, win[SYM_BITS-1] the oldest.
  function automatic logic [SYM_BITS-1:0] arrange_sym(
    input mod_e m, input logic rev, input logic [SYM_BITS-1:0] win);
    logic [SYM_BITS-1:0] s;
    unique case (m)
      MOD_BPSK: s = {SYM_BITS{win[0]}};
      MOD_QPSK: s = rev ? {win[0], win[1], win[0], win[1]}
                        : {win[1], win[0], win[1], win[0]};
      default:  s = rev ? {win[0], win[1], win[2], win[3]} : win;
    endcase
    return s;
  endfunction

  function automatic logic [QUAD_BITS-1:0] diff_quad(
    input logic [QUAD_BITS-1:0] in_q, input logic [QUAD_BITS-1:0] ref_q,
    input logic en);
    return en ? (in_q ^ ref_q) : in_q;
  endfunction
endpackage

// File: rtl/diffmap_gather.sv
module diffmap_gather
  import diffmap_pkg::*;
#(
  parameter int WIN_W = SYM_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_now
);
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_nxt;

  assign win_nxt[0] = bit_in;
  for (genvar g = 1; g < WIN_W; g++) begin : g_shift
    assign win_nxt[g] = win_q[g-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       win_q <= '0;
    else if (bit_stb) win_q <= win_nxt;
  end

  // A bit arriving with the symbol strobe belongs to that symbol.
  assign win_now = bit_stb ? win_nxt : win_q;

  AST_WIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> win_q[0] == $past(bit_in)) else $error("window shift");  // R2
endmodule

// File: rtl/diffmap_arrange.sv
module diffmap_arrange
  import diffmap_pkg::*;
(
  input  mod_e                mod,
  input  logic [2:0]          map_sel,
  input  logic [SYM_BITS-1:0] win,
  output logic [SYM_BITS-1:0] raw_sym
);
  logic rev;
  assign rev     = map_sel[2];
  assign raw_sym = arrange_sym(mod, rev, win);

  always_comb begin
    if (mod == MOD_QPSK || mod == MOD_BPSK)
      AST_PAIR_COPY: assert (raw_sym[3] == raw_sym[1] && raw_sym[2] == raw_sym[0]) // R4
        else $error("pair copy");
  end
endmodule

// File: rtl/diffmap_encoder.sv
module diffmap_encoder
  import diffmap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_stb,
  input  logic                diff_en,
  input  mod_e                mod,
  input  logic [SYM_BITS-1:0] raw_sym,
  output logic [SYM_BITS-1:0] sym_q,
  output logic                vld_q
);
  logic [QUAD_BITS-1:0] ref_q;
  logic                 prev_en_q;
  logic                 zero_ref;
  logic [QUAD_BITS-1:0] ref_sel;
  logic [QUAD_BITS-1:0] quad;
  logic [QUAD_BITS-1:0] fine;

  assign zero_ref = diff_en && !prev_en_q;
  assign ref_sel  = zero_ref ? '0 : ref_q;
  assign quad     = diff_quad(raw_sym[SYM_BITS-1 -: QUAD_BITS], ref_sel, diff_en);
  assign fine     = is_qam16(mod) ? raw_sym[QUAD_BITS-1:0] : quad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q     <= '0;
      prev_en_q <= 1'b0;
      sym_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= sym_stb;
      if (sym_stb) begin
        sym_q     <= {quad, fine};
        ref_q     <= quad;
        prev_en_q <= diff_en;
      end
    end
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> vld_q) else $error("vld missing");  // R2
  AST_VLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(sym_stb)) else $error("vld spurious");  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(sym_q)) else $error("symbol not held");  // R2
  AST_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !diff_en) |=> sym_q[3:2] == $past(raw_sym[3:2])) else $error("pass");  // R10
  AST_QAM_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && is_qam16(mod)) |=> sym_q[1:0] == $past(raw_sym[1:0])) else $error("fine");  // R8
  AST_ZERO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && zero_ref) |=> sym_q[3:2] == $past(raw_sym[3:2])) else $error("zero ref");  // R9
endmodule

// File: rtl/diffmap_top.sv
module diffmap_top
  import diffmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  input  logic       sym_stb,
  input  logic [1:0] mod_sel,
  input  logic       diff_en,
  input  logic [2:0] map_sel,
  output logic [3:0] sym_out,
  output logic       sym_vld
);
  mod_e                mod;
  logic [SYM_BITS-1:0] win;
  logic [SYM_BITS-1:0] raw_sym;

  assign mod = mod_e'(mod_sel);

  diffmap_gather #(.WIN_W(SYM_BITS)) i_gather (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in), .win_now(win));

  diffmap_arrange i_arrange (
    .mod(mod), .map_sel(map_sel), .win(win), .raw_sym(raw_sym));

  diffmap_encoder i_encoder (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .diff_en(diff_en), .mod(mod),
    .raw_sym(raw_sym), .sym_q(sym_out), .vld_q(sym_vld));

  AST_QPSK_OUT_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !mod_sel[1]) |=> (sym_out[3] == sym_out[1] && sym_out[2] == sym_out[0]))
    else $error("qpsk pairs");  // R4
endmodule

// File: tb/test_diffmap_top.sv
module test_diffmap_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, bit_in = 1'b0, sym_stb = 1'b0, diff_en = 1'b0;
  logic [1:0] mod_sel = 2'b00;
  logic [2:0] map_sel = 3'b000;
  logic [3:0] sym_out;
  logic sym_vld;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  typedef struct { logic [3:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  logic [1:0] m_ref = 2'b00;
  logic       m_prev = 1'b0;
  logic [3:0] last_out = 4'b0000;

  always #5 clk = ~clk;

  diffmap_top i_diffmap_top (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in), .sym_stb(sym_stb),
    .mod_sel(mod_sel), .diff_en(diff_en), .map_sel(map_sel),
    .sym_out(sym_out), .sym_vld(sym_vld));

  task automatic check(input bit ok, input string tag, input logic [3:0] act,
                       input logic [3:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Model: b[0] is the first bit sent.
  function automatic logic [3:0] model_raw(input logic [1:0] m, input logic rv,
                                           input logic [3:0] b);
    if (m == 2'b00) return {b[0], b[0], b[0], b[0]};
    if (m == 2'b01) return rv ? {b[1], b[0], b[1], b[0]} : {b[0], b[1], b[0], b[1]};
    return rv ? {b[3], b[2], b[1], b[0]} : {b[0], b[1], b[2], b[3]};
  endfunction

  task automatic send(input logic [1:0] m, input logic [3:0] b, input logic d,
                      input logic [2:0] mp, input string tag);
    int n;
    logic [3:0] raw;
    logic [1:0] q, r;
    exp_t e;
    n = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_stb = 1'b1;
      bit_in  = b[i];
    end
    @(negedge clk);
    bit_stb = 1'b0;
    mod_sel = m; diff_en = d; map_sel = mp; sym_stb = 1'b1;
    raw = model_raw(m, mp[2], b);
    r = m_prev ? m_ref : 2'b00;
    q = d ? (raw[3:2] ^ r) : raw[3:2];
    e.val = {q, m[1] ? raw[1:0] : q};
    e.tag = tag;
    sb_q.push_back(e);
    m_ref = q;
    m_prev = d;
    @(negedge clk);
    sym_stb = 1'b0;
  endtask

  // Monitor: result due one clock after the sampling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_vld) begin
        if (sb_q.size() == 0) check(1'b0, "R2 unexpected vld", sym_out, 4'bx);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(sym_out === e.val, e.tag, sym_out, e.val);
        end
        last_out = sym_out;
      end else begin
        check(sym_out === last_out, "R2 hold", sym_out, last_out);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sym_vld === 1'b0, "R1 vld reset", {3'b0, sym_vld}, 4'b0);
    check(sym_out === 4'b0000, "R1 out reset", sym_out, 4'b0000);
    rst_n = 1'b1;
    // R1/R9: first diff symbol after reset against zero
    send(2'b10, 4'b1101, 1'b1, 3'b000, "R1 first diff symbol");
    send(2'b10, 4'b0111, 1'b1, 3'b000, "R7 continuous diff");
    send(2'b10, 4'b1011, 1'b1, 3'b000, "R8 fine bits pass diff");
    send(2'b01, 4'b0001, 1'b1, 3'b000, "R7 qpsk diff");
    send(2'b00, 4'b0001, 1'b1, 3'b000, "R3 bpsk 180 flip");
    send(2'b00, 4'b0000, 1'b1, 3'b000, "R3 bpsk no change");
    send(2'b00, 4'b0001, 1'b0, 3'b000, "R3 bpsk plain one");
    send(2'b00, 4'b0000, 1'b0, 3'b000, "R3 bpsk plain zero");
    send(2'b01, 4'b0001, 1'b0, 3'b000, "R4 qpsk b0 to I");
    send(2'b01, 4'b0010, 1'b0, 3'b000, "R4 qpsk b1 to Q");
    send(2'b10, 4'b0001, 1'b0, 3'b000, "R5 qam b0 to I1");
    send(2'b11, 4'b1000, 1'b0, 3'b000, "R5 qam alt code b3 to Q0");
    send(2'b10, 4'b0011, 1'b0, 3'b100, "R6 qam reversed");
    send(2'b01, 4'b0001, 1'b0, 3'b100, "R6 qpsk reversed");
    send(2'b00, 4'b0001, 1'b0, 3'b100, "R6 bpsk unaffected");
    send(2'b10, 4'b0011, 1'b0, 3'b011, "R6 low map bits ignored");
    send(2'b10, 4'b1111, 1'b0, 3'b000, "R10 diff off preamble");
    send(2'b10, 4'b1111, 1'b1, 3'b000, "R9 zero ref on enable");
    send(2'b10, 4'b0110, 1'b1, 3'b000, "R7 after zero ref");
    send(2'b10, 4'b0101, 1'b0, 3'b000, "R10 diff off");
    for (int k = 0; k < 60; k++) begin
      logic [3:0] rb;
      logic [1:0] rm;
      logic rd;
      logic [2:0] rmp;
      rb = 4'($urandom); rm = 2'($urandom); rd = 1'($urandom); rmp = 3'($urandom);
      send(rm, rb, rd, rmp, "R7 random mix");
    end
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 all symbols produced", 4'(sb_q.size()), 4'b0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", 4'b0, 4'b0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule